// File: doc/BRIEF.md
# SPI Master Channel with Word-Count Clocking

This block is one master channel of a serial peripheral interface. A host programs it through a small memory-mapped register bus. Words of 8, 16 or 32 bits go into a transmit FIFO, leave on MOSI MSB first, and come back from MISO into a receive FIFO. The serial clock comes from the system clock through an 8-bit prescaler. The clock can be gated off, and its idle level and sampling edge follow the four usual SPI modes. The single chip-select output is a plain register bit.

There are two ways to decide how many words are clocked. By default the shifter runs while transmit is enabled and the transmit FIFO holds data. When the word counter is armed, the shifter clocks exactly the programmed number of words and then stops, whether or not transmit data is present; missing transmit data goes out as zeros. This lets a receive-only transfer produce exactly the clocks it needs. Receive stays enabled on transmit-only transfers so that the counter can still set the clock count.

Top module: `spi_pkt_master`

## Requirements
- R1: After reset, cs_n_o is 1, sclk_o is 0, all configuration registers read 0, and the status register reads only the done flag (bit 25) set.
- R2: Each SCLK half period lasts (P+1) system clock cycles, where P is clock config bits [7:0], so SCLK runs at clk/(2(P+1)). While clock config bit 8 is 0, no SCLK edge occurs and no word leaves the TX FIFO.
- R3: Channel config bit 3 (CPOL) sets the SCLK idle level. With bit 2 (CPHA) at 0, MOSI and MISO are valid on the first edge of each bit; with CPHA at 1 they are valid on the second edge. Words shift MSB first, and consecutive words follow each other with no gap.
- R4: Mode config bits [30:29] select the word size: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits. A word takes exactly 2×size SCLK edges, and received words are zero-extended to 32 bits.
- R5: With the word counter disarmed, one word is clocked for each TX FIFO entry while channel config bit 0 (TX enable) is 1, and clocking stops when the FIFO is empty.
- R6: Writing the count register at 0x20 with bit 16 set and a count N in bits [15:0] clocks exactly N words and then idles. Words missing from the TX FIFO (or all words when TX is off) shift out as zeros.
- R7: Writing 0 to bit 0 of the select register (0x0C) drives cs_n_o low from the next cycle on; writing 1 drives it high.
- R8: Status (0x14) holds the TX FIFO level in bits [12:6] and the RX FIFO level in bits [21:15]. Bit 25 is 1 exactly when the TX FIFO is empty and the shifter is idle.
- R9: A read of RX data (0x1C) while the RX FIFO is empty returns 0 and leaves the RX level unchanged. With channel config bit 1 (RX enable) set, each finished word is pushed into the RX FIFO.
- R10: While channel config bit 5 is 1, both FIFOs are held empty and the shifter is stopped.
- R11: Each FIFO holds 64 words. A write to TX data when the TX FIFO is full is dropped, and the level stays at 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 6 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, valid one cycle after the read strobe |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_n_o | output | 1 | Active-low chip select |

## Verification
Register writes take effect at the edge that samples the strobe. Read data appears one cycle after the read strobe, so the bench drives strobes at the falling edge and collects data at the next falling edge. A shift starts on the cycle after the enabling write, and its first SCLK edge follows P+1 cycles later. Once started, every edge must be exactly P+1 cycles after the previous one. The bench therefore timestamps every SCLK edge and checks each gap. It waits a few cycles before polling the done flag, so that the flag cannot be read in the cycle before the shifter goes busy. The bench's own slave model samples MOSI using the value from the preceding falling edge of the system clock. Because of this, a word loaded on the final SCLK edge is never mistaken for the bit just sampled.

// File: rtl/spi_pkt_pkg.sv
`timescale 1ns/1ps
package spi_pkt_pkg;
  localparam int REG_AW = 6;
  localparam int WORD_W = 32;

  // register byte offsets
  localparam logic [REG_AW-1:0] A_CHAN = 6'h00;
  localparam logic [REG_AW-1:0] A_CLK  = 6'h04;
  localparam logic [REG_AW-1:0] A_MODE = 6'h08;
  localparam logic [REG_AW-1:0] A_SEL  = 6'h0C;
  localparam logic [REG_AW-1:0] A_STAT = 6'h14;
  localparam logic [REG_AW-1:0] A_TXD  = 6'h18;
  localparam logic [REG_AW-1:0] A_RXD  = 6'h1C;
  localparam logic [REG_AW-1:0] A_PKT  = 6'h20;

  // field positions
  localparam int ST_TXLVL_LSB = 6;
  localparam int ST_RXLVL_LSB = 15;
  localparam int ST_DONE_BIT  = 25;
  localparam int MODE_CH_LSB  = 29;
  localparam int MODE_BUS_LSB = 17;

  typedef enum logic [1:0] {
    WS_BYTE = 2'd0,
    WS_HALF = 2'd1,
    WS_WORD = 2'd2
  } wsize_e;

  typedef struct packed {
    logic swrst;
    logic slave;
    logic cpol;
    logic cpha;
    logic rx_on;
    logic tx_on;
  } chan_cfg_t;

  function automatic logic [5:0] word_bits(input logic [1:0] sz);
    case (sz)
      WS_BYTE: word_bits = 6'd8;
      WS_HALF: word_bits = 6'd16;
      default: word_bits = 6'd32;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] word_mask(input logic [1:0] sz);
    case (sz)
      WS_BYTE: word_mask = 32'h0000_00FF;
      WS_HALF: word_mask = 32'h0000_FFFF;
      default: word_mask = 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/spi_pkt_fifo.sv
`timescale 1ns/1ps
module spi_pkt_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 64
) (
  input  logic                           clk_i,
  input  logic                           rst_i,
  input  logic                           flush_i,
  input  logic                           push_i,
  input  logic [WIDTH-1:0]               wdata_i,
  input  logic                           pop_i,
  output logic [WIDTH-1:0]               rdata_o,
  output logic                           empty_o,
  output logic                           full_o,
  output logic [$clog2(DEPTH+1)-1:0]     level_o
);
  localparam int PTRW = $clog2(DEPTH);
  localparam int LVLW = $clog2(DEPTH+1);
  localparam logic [LVLW-1:0] LVL_MAX = LVLW'(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTRW-1:0]  wr_q, rd_q;
  logic [LVLW-1:0]  lvl_q;
  logic             do_push, do_pop;

  assign empty_o = (lvl_q == '0);
  assign full_o  = (lvl_q == LVL_MAX);
  assign do_push = push_i & ~full_o & ~flush_i;
  assign do_pop  = pop_i & ~empty_o & ~flush_i;
  assign rdata_o = mem_q[rd_q];
  assign level_o = lvl_q;

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i || flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (do_push) wr_q <= wr_q + PTRW'(1);
      if (do_pop)  rd_q <= rd_q + PTRW'(1);
      case ({do_push, do_pop})
        2'b10:   lvl_q <= lvl_q + LVLW'(1);
        2'b01:   lvl_q <= lvl_q - LVLW'(1);
        default: lvl_q <= lvl_q;
      endcase
    end
  end

  p_level_bound_r11: assert property (@(posedge clk_i) disable iff (rst_i)
    lvl_q <= LVL_MAX);
  p_full_drop_r11: assert property (@(posedge clk_i) disable iff (rst_i)
    (full_o && push_i && !pop_i && !flush_i) |=> (lvl_q == LVL_MAX));
  p_flush_empty_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    flush_i |=> empty_o);
endmodule

// File: rtl/spi_pkt_engine.sv
`timescale 1ns/1ps
module spi_pkt_engine
  import spi_pkt_pkg::*;
#(
  parameter int PSR_W = 8,
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              flush_i,
  input  logic              clk_en_i,
  input  logic [PSR_W-1:0]  psr_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic [1:0]        wsize_i,
  input  logic              tx_on_i,
  input  logic              rx_on_i,
  input  logic              pkt_en_i,
  input  logic              pkt_load_i,
  input  logic [CNT_W-1:0]  pkt_val_i,
  input  logic              tx_empty_i,
  input  logic [WORD_W-1:0] tx_data_i,
  output logic              tx_pop_o,
  output logic              rx_push_o,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              busy_o,
  output logic [CNT_W-1:0]  left_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i
);
  logic              busy_q, sclk_q;
  logic [PSR_W-1:0]  div_q;
  logic [6:0]        edge_q;
  logic [WORD_W-1:0] tx_sh_q, rx_sh_q;
  logic [CNT_W-1:0]  left_q;

  logic [6:0] edge_last;
  logic take_tx, have_word, tick, samp, last, shift_now, start;

  assign edge_last = {word_bits(wsize_i), 1'b0} - 7'd1;
  assign take_tx   = tx_on_i & ~tx_empty_i;
  assign have_word = pkt_en_i ? (left_q != '0) : take_tx;
  assign tick      = busy_q & clk_en_i & (div_q == psr_i);
  assign samp      = (edge_q[0] == cpha_i);
  assign last      = (edge_q == edge_last);
  // launch edges move the shifter, except the final edge and the CPHA=1 lead-in
  assign shift_now = tick & ~samp & ~last & ~(cpha_i & (edge_q == 7'd0));
  assign start     = clk_en_i & ~flush_i & have_word & (~busy_q | (tick & last));

  assign tx_pop_o  = start & take_tx;
  assign rx_push_o = tick & last & rx_on_i & ~flush_i;
  assign rx_data_o = (cpha_i ? {rx_sh_q[WORD_W-2:0], miso_i} : rx_sh_q) & word_mask(wsize_i);
  assign busy_o    = busy_q;
  assign left_o    = left_q;
  assign sclk_o    = sclk_q;

  always_comb begin
    case (wsize_i)
      WS_BYTE: mosi_o = tx_sh_q[7];
      WS_HALF: mosi_o = tx_sh_q[15];
      default: mosi_o = tx_sh_q[WORD_W-1];
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      busy_q  <= 1'b0;
      sclk_q  <= 1'b0;
      div_q   <= '0;
      edge_q  <= '0;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
      left_q  <= '0;
    end else begin
      if (pkt_load_i)             left_q <= pkt_val_i;
      else if (start && pkt_en_i) left_q <= left_q - CNT_W'(1);

      if (flush_i) begin
        busy_q <= 1'b0;
        sclk_q <= cpol_i;
        div_q  <= '0;
      end else if (start) begin
        busy_q  <= 1'b1;
        sclk_q  <= cpol_i;
        div_q   <= '0;
        edge_q  <= '0;
        tx_sh_q <= take_tx ? tx_data_i : '0;
      end else if (tick) begin
        div_q  <= '0;
        sclk_q <= ~sclk_q;
        edge_q <= edge_q + 7'd1;
        if (samp)      rx_sh_q <= {rx_sh_q[WORD_W-2:0], miso_i};
        if (shift_now) tx_sh_q <= tx_sh_q << 1;
        if (last)      busy_q  <= 1'b0;
      end else if (busy_q) begin
        if (clk_en_i) div_q <= div_q + PSR_W'(1);
      end else begin
        sclk_q <= cpol_i;
      end
    end
  end

  p_sclk_idle_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (!busy_q && !$past(busy_q)) |-> (sclk_q == $past(cpol_i)));
  p_pkt_stop_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (pkt_en_i && left_q == '0 && !busy_q) |=> !busy_q);
  p_gate_hold_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy_q && !clk_en_i && !flush_i) |=> $stable(sclk_q));
endmodule

// File: rtl/spi_pkt_master.sv
`timescale 1ns/1ps
module spi_pkt_master
  import spi_pkt_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int PSR_W      = 8,
  parameter int CNT_W      = 16
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              cs_n_o
);
  localparam int LVLW = $clog2(FIFO_DEPTH+1);

  chan_cfg_t        chan_q;
  logic [PSR_W-1:0] psr_q;
  logic             clk_en_q;
  logic [1:0]       ch_sz_q, bus_sz_q;
  logic             sel_q, pkt_en_q;
  logic [WORD_W-1:0] rdata_q;

  logic wr_chan, wr_clk, wr_mode, wr_sel, wr_pkt, wr_txd, rd_rxd;
  assign wr_chan = reg_we_i && reg_addr_i == A_CHAN;
  assign wr_clk  = reg_we_i && reg_addr_i == A_CLK;
  assign wr_mode = reg_we_i && reg_addr_i == A_MODE;
  assign wr_sel  = reg_we_i && reg_addr_i == A_SEL;
  assign wr_pkt  = reg_we_i && reg_addr_i == A_PKT;
  assign wr_txd  = reg_we_i && reg_addr_i == A_TXD;
  assign rd_rxd  = reg_re_i && reg_addr_i == A_RXD;

  logic [WORD_W-1:0] tx_head, rx_head, rx_word;
  logic tx_empty, tx_full, rx_empty, rx_full;
  logic [LVLW-1:0] tx_lvl, rx_lvl;
  logic tx_pop, rx_push, busy;
  logic [CNT_W-1:0] left;

  logic unused_ok;
  assign unused_ok = ^{tx_full, rx_full};

  spi_pkt_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) tx_fifo_i (
    .clk_i(clk_i), .rst_i(rst_i), .flush_i(chan_q.swrst),
    .push_i(wr_txd), .wdata_i(reg_wdata_i), .pop_i(tx_pop),
    .rdata_o(tx_head), .empty_o(tx_empty), .full_o(tx_full), .level_o(tx_lvl));

  spi_pkt_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) rx_fifo_i (
    .clk_i(clk_i), .rst_i(rst_i), .flush_i(chan_q.swrst),
    .push_i(rx_push), .wdata_i(rx_word), .pop_i(rd_rxd),
    .rdata_o(rx_head), .empty_o(rx_empty), .full_o(rx_full), .level_o(rx_lvl));

  spi_pkt_engine #(.PSR_W(PSR_W), .CNT_W(CNT_W)) engine_i (
    .clk_i(clk_i), .rst_i(rst_i), .flush_i(chan_q.swrst),
    .clk_en_i(clk_en_q), .psr_i(psr_q),
    .cpol_i(chan_q.cpol), .cpha_i(chan_q.cpha), .wsize_i(ch_sz_q),
    .tx_on_i(chan_q.tx_on), .rx_on_i(chan_q.rx_on),
    .pkt_en_i(pkt_en_q), .pkt_load_i(wr_pkt), .pkt_val_i(reg_wdata_i[CNT_W-1:0]),
    .tx_empty_i(tx_empty), .tx_data_i(tx_head), .tx_pop_o(tx_pop),
    .rx_push_o(rx_push), .rx_data_o(rx_word), .busy_o(busy), .left_o(left),
    .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(miso_i));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      chan_q   <= '0;
      psr_q    <= '0;
      clk_en_q <= 1'b0;
      ch_sz_q  <= 2'd0;
      bus_sz_q <= 2'd0;
      sel_q    <= 1'b1;
      pkt_en_q <= 1'b0;
    end else begin
      if (wr_chan) chan_q <= chan_cfg_t'(reg_wdata_i[5:0]);
      if (wr_clk) begin
        psr_q    <= reg_wdata_i[PSR_W-1:0];
        clk_en_q <= reg_wdata_i[PSR_W];
      end
      if (wr_mode) begin
        ch_sz_q  <= reg_wdata_i[MODE_CH_LSB +: 2];
        bus_sz_q <= reg_wdata_i[MODE_BUS_LSB +: 2];
      end
      if (wr_sel) sel_q    <= reg_wdata_i[0];
      if (wr_pkt) pkt_en_q <= reg_wdata_i[CNT_W];
    end
  end

  logic [WORD_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (reg_addr_i)
      A_CHAN: rd_mux[5:0] = chan_q;
      A_CLK:  rd_mux[PSR_W:0] = {clk_en_q, psr_q};
      A_MODE: begin
        rd_mux[MODE_CH_LSB +: 2]  = ch_sz_q;
        rd_mux[MODE_BUS_LSB +: 2] = bus_sz_q;
      end
      A_SEL:  rd_mux[0] = sel_q;
      A_STAT: begin
        rd_mux[ST_TXLVL_LSB +: LVLW] = tx_lvl;
        rd_mux[ST_RXLVL_LSB +: LVLW] = rx_lvl;
        rd_mux[ST_DONE_BIT]          = tx_empty & ~busy;
      end
      A_RXD:  rd_mux = rx_empty ? '0 : rx_head;
      A_PKT:  rd_mux[CNT_W:0] = {pkt_en_q, left};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)         rdata_q <= '0;
    else if (reg_re_i) rdata_q <= rd_mux;
  end

  assign reg_rdata_o = rdata_q;
  assign cs_n_o      = sel_q;

  p_cs_follow_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_sel |=> (cs_n_o == $past(reg_wdata_i[0])));
  p_rx_empty_zero_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    (rd_rxd && rx_empty) |=> (reg_rdata_o == '0));
  p_rx_empty_keep_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    (rd_rxd && rx_empty && !rx_push) |=> (rx_lvl == $past(rx_lvl)));
endmodule

// File: tb/spi_pkt_master_tb_top.sv
`timescale 1ns/1ps
module spi_pkt_master_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic we = 1'b0, re = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic sclk, mosi, miso, cs_n;

  always #10 clk = ~clk;

  spi_pkt_master dut_i (
    .clk_i(clk), .rst_i(rst), .reg_we_i(we), .reg_re_i(re),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso), .cs_n_o(cs_n));

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // bench slave / monitor state
  bit m_cpol = 0, m_cpha = 0;
  int m_psr = 0;
  int edges = 0, gap_err = 0;
  time last_t = 0;
  bit first_e = 1, slv_first = 1;
  logic [127:0] slv_sr = '0, mon_sr = '0;
  logic mosi_prev = 1'b0;

  assign miso = slv_sr[127];
  always @(negedge clk) mosi_prev = mosi;

  task automatic on_edge(input bit rise);
    bit lead;
    lead = (rise != m_cpol);
    edges++;
    if (!first_e && (($time - last_t) != time'((m_psr + 1) * 20))) gap_err++;
    first_e = 0;
    last_t  = $time;
    if (lead == !m_cpha) mon_sr = {mon_sr[126:0], mosi_prev};
    else if (!m_cpha) slv_sr = slv_sr << 1;
    else if (slv_first) slv_first = 0;
    else slv_sr = slv_sr << 1;
  endtask

  always @(posedge sclk) on_edge(1'b1);
  always @(negedge sclk) on_edge(1'b0);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); re = 1'b1; addr = a;
    @(negedge clk); d = rdata; re = 1'b0;
  endtask

  task automatic run_case(input int mode, input int sz, input int psr,
                          input int nw, input bit pkt, input int seed);
    int n;
    logic [31:0] mask, d;
    logic [31:0] tw [8];
    logic [127:0] pat, exp_mosi;
    logic [31:0] cfg;
    n    = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    mask = (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
    m_cpol = mode[1]; m_cpha = mode[0]; m_psr = psr;
    cfg = {28'd0, m_cpol, m_cpha, 1'b1, 1'b0};
    wr(6'h00, 32'h20);
    wr(6'h20, 32'h0);
    wr(6'h04, 32'h100 | psr);
    wr(6'h08, (sz << 29) | (sz << 17));
    wr(6'h00, cfg);
    repeat (3) @(negedge clk);
    chk(sclk == m_cpol, "R3", "sclk idle level", 128'(sclk), 128'(m_cpol));
    pat = {32'hC3A5_9E17 ^ 32'(seed), 32'h5B0D_E26F + 32'(seed),
           32'h8F13_47AC ^ 32'(seed << 3), 32'h2468_ACE1};
    edges = 0; gap_err = 0; first_e = 1; mon_sr = '0; slv_sr = pat; slv_first = 1;
    exp_mosi = '0;
    for (int k = 0; k < nw; k++) begin
      tw[k] = (32'h9E37_79B9 * 32'(k + 1 + seed)) & mask;
      if (!pkt) wr(6'h18, tw[k]);
      exp_mosi = (exp_mosi << n) | (pkt ? 128'd0 : 128'(tw[k]));
    end
    if (pkt) wr(6'h20, 32'h1_0000 | nw);
    else     wr(6'h00, cfg | 32'h1);
    repeat (4) @(negedge clk);
    for (int i = 0; i < 5000; i++) begin
      rd(6'h14, d);
      if (d[25]) break;
    end
    // R4 / R5 / R6: exact number of edges
    chk(edges == 2 * n * nw, pkt ? "R6" : "R5", "sclk edge count",
        128'(edges), 128'(2 * n * nw));
    chk(gap_err == 0, "R2", "half period gaps", 128'(gap_err), 128'd0);
    chk(mon_sr == exp_mosi, "R3", "mosi bit stream", mon_sr, exp_mosi);
    rd(6'h14, d);
    chk(d[21:15] == 7'(nw), "R8", "rx level", 128'(d[21:15]), 128'(nw));
    for (int k = 0; k < nw; k++) begin
      logic [31:0] e;
      e = 32'((pat >> (128 - (k + 1) * n))) & mask;
      rd(6'h1C, d);
      chk(d == e, "R4", "rx word", 128'(d), 128'(e));
    end
    wr(6'h00, cfg);
    wr(6'h20, 32'h0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(cs_n == 1'b1, "R1", "cs_n after reset", 128'(cs_n), 128'd1);
    chk(sclk == 1'b0, "R1", "sclk after reset", 128'(sclk), 128'd0);
    rd(6'h14, d);
    chk(d == 32'h0200_0000, "R1", "status after reset", 128'(d), 128'h0200_0000);
    rd(6'h04, d);
    chk(d == 32'h0, "R1", "clock config after reset", 128'(d), 128'd0);
    rd(6'h00, d);
    chk(d == 32'h0, "R1", "channel config after reset", 128'(d), 128'd0);

    // R7 chip select
    wr(6'h0C, 32'h0);
    chk(cs_n == 1'b0, "R7", "cs_n active", 128'(cs_n), 128'd0);
    wr(6'h0C, 32'h1);
    chk(cs_n == 1'b1, "R7", "cs_n inactive", 128'(cs_n), 128'd1);

    // R9 empty RX read
    rd(6'h1C, d);
    chk(d == 32'h0, "R9", "empty rx read", 128'(d), 128'd0);
    rd(6'h14, d);
    chk(d[21:15] == 7'd0, "R9", "rx level after empty read", 128'(d[21:15]), 128'd0);

    // sweep: four modes x three word sizes, FIFO-driven
    for (int mode = 0; mode < 4; mode++)
      for (int sz = 0; sz < 3; sz++) begin
        int p;
        p = ((mode + sz) % 3 == 0) ? 0 : ((mode + sz) % 3 == 1) ? 1 : 3;
        run_case(mode, sz, p, 3, 1'b0, mode * 7 + sz);
      end
    // counted transfers, TX off (R6)
    run_case(0, 0, 1, 5, 1'b1, 11);
    run_case(3, 1, 0, 5, 1'b1, 23);
    run_case(1, 2, 3, 3, 1'b1, 37);
    run_case(2, 0, 3, 7, 1'b1, 41);

    // R2 gating: clock off, data waiting, TX on
    wr(6'h00, 32'h20);
    wr(6'h00, 32'h0);
    wr(6'h04, 32'h000);
    wr(6'h18, 32'hAB);
    m_cpol = 0;
    edges = 0;
    wr(6'h00, 32'h3);
    repeat (60) @(negedge clk);
    chk(edges == 0, "R2", "no edges with clock gated", 128'(edges), 128'd0);
    rd(6'h14, d);
    chk(d[12:6] == 7'd1, "R2", "tx word held while gated", 128'(d[12:6]), 128'd1);
    wr(6'h00, 32'h0);

    // R11 overfill TX FIFO
    for (int k = 0; k < 66; k++) wr(6'h18, 32'(k));
    rd(6'h14, d);
    chk(d[12:6] == 7'd64, "R11", "tx level saturates", 128'(d[12:6]), 128'd64);
    chk(d[25] == 1'b0, "R8", "done flag low with data", 128'(d[25]), 128'd0);

    // R10 soft reset flushes
    wr(6'h00, 32'h20);
    rd(6'h14, d);
    chk(d[12:6] == 7'd0 && d[21:15] == 7'd0, "R10", "levels during soft reset",
        128'(d[21:6]), 128'd0);
    wr(6'h18, 32'h55);
    rd(6'h14, d);
    chk(d[12:6] == 7'd0, "R10", "write ignored during soft reset", 128'(d[12:6]), 128'd0);
    wr(6'h00, 32'h0);
    rd(6'h14, d);
    chk(d == 32'h0200_0000, "R8", "status idle and empty", 128'(d), 128'h0200_0000);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule